// File: doc/BRIEF.md
# Data Array Byte Parity Guard

This block protects the data array of a cache with one parity bit per byte. On the write path it takes a data word, byte enables and a source flag. The source flag tells a store hit from a line refill. The block returns a parity bit for every byte lane and a per-lane write strobe for the parity storage. A test mode deliberately corrupts the stored parity. While it is on, every written parity bit is inverted, on store hits and refills alike, whatever the state of error checking.

On the read path the block recomputes parity from the data it is given and compares the result with the stored bits. A mismatch seen while reporting is enabled sets a sticky error flag and records the failing lanes. Reporting needs two conditions: the checking enable is 1, and the detection-type field selects parity. The flag is registered and stays set until software writes a zero to it.

Top module: `byte_parity_guard`

## Requirements
- R1: `wr_par[i]` is the XOR of the eight bits `wr_data[8*i+7:8*i]` (even parity), when injection is off.
- R2: `wr_par_we` equals `wr_be` while `wr_valid` is 1, and is all zeros while `wr_valid` is 0.
- R3: While `inj_en` is 1, every bit of `wr_par` is the inverse of its R1 value, whether `chk_en` is 0 or 1.
- R4: `wr_src` (0 = store hit, 1 = line refill) has no effect on `wr_par`. Injection applies to both sources.
- R5: A read with `rd_valid` = 1, reporting enabled and a nonzero mismatch vector sets `err_flag` at the clock edge that samples the read. The flag is therefore visible one cycle after the read data is valid. The mismatch vector is the recomputed parity XOR `rd_par`. At the same edge, `err_lanes` takes the mismatch vector, with bit i set for each failing byte lane i.
- R6: While `chk_en` is 0, no read changes `err_flag` or `err_lanes`.
- R7: `det_type` values 2'b00 and 2'b01 both select parity checking and behave identically. Any value with `det_type[1]` = 1 disables reporting.
- R8: Once set, `err_flag` stays 1. `err_lanes` keeps the first captured lanes through later failing reads.
- R9: A cycle with `clr_we` = 1 and `clr_val` = 0 clears `err_flag` and `err_lanes`. With `clr_val` = 1 the write has no effect. If a reported error arrives in the same cycle as a clear, the error wins and `err_lanes` takes the new lanes.
- R10: After reset, `err_flag` is 0 and `err_lanes` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Error checking and reporting enable |
| inj_en | input | 1 | Parity error injection enable |
| det_type | input | 2 | Detection type; 00/01 parity, 1x reporting off |
| wr_valid | input | 1 | Write to the data array this cycle |
| wr_src | input | 1 | 0 store hit, 1 line refill |
| wr_be | input | DATA_W/8 | Byte enables of the write |
| wr_data | input | DATA_W | Write data |
| wr_par | output | DATA_W/8 | Parity bits to store |
| wr_par_we | output | DATA_W/8 | Per-lane parity write strobe |
| rd_valid | input | 1 | Read data valid this cycle |
| rd_data | input | DATA_W | Data read from the array |
| rd_par | input | DATA_W/8 | Parity bits read from the array |
| clr_we | input | 1 | Software write to the error flag |
| clr_val | input | 1 | Value written; 0 clears |
| err_flag | output | 1 | Sticky parity error flag |
| err_lanes | output | DATA_W/8 | Byte lanes of the captured error |

## Verification
The assertions assume `clr_we`, `chk_en` and `det_type` are steady for the whole cycle they are sampled in. They also assume a clear is judged only in cycles with no read. The bench drives every input at the falling edge and keeps each one stable until the next falling edge. Every clear-only check runs with `rd_valid` low. The set-versus-clear collision is exercised on purpose in one directed cycle. In that cycle the property that expects the flag to drop does not apply, because `rd_valid` is high.

// File: rtl/byte_parity_guard.sv
module byte_parity_guard #(
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic                  inj_en,
  input  logic [1:0]            det_type,
  input  logic                  wr_valid,
  input  logic                  wr_src,
  input  logic [DATA_W/8-1:0]   wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W/8-1:0]   wr_par,
  output logic [DATA_W/8-1:0]   wr_par_we,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [DATA_W/8-1:0]   rd_par,
  input  logic                  clr_we,
  input  logic                  clr_val,
  output logic                  err_flag,
  output logic [DATA_W/8-1:0]   err_lanes
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0] wr_raw, rd_raw, mism;
  logic          report_ok, hit, sw_clr, unused_src;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign wr_raw[g] = ^wr_data[8*g +: 8];
    assign rd_raw[g] = ^rd_data[8*g +: 8];
  end

  assign unused_src = wr_src;
  assign wr_par     = wr_raw ^ {NB{inj_en}};
  assign wr_par_we  = wr_valid ? wr_be : '0;

  assign mism      = rd_raw ^ rd_par;
  assign report_ok = chk_en && !det_type[1];
  assign hit       = rd_valid && report_ok && (|mism);
  assign sw_clr    = clr_we && !clr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_lanes <= '0;
    end else if (hit && (!err_flag || sw_clr)) begin
      err_flag  <= 1'b1;
      err_lanes <= mism;
    end else if (!hit && sw_clr) begin
      err_flag  <= 1'b0;
      err_lanes <= '0;
    end
  end

  // R2
  always_comb begin
    we_subset_chk: assert ((wr_par_we & ~wr_be) == '0);
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(clr_we && !clr_val) |=> err_flag);

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(rd_valid && chk_en && !det_type[1]));

  // R5
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_lanes != '0);

  // R9
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && clr_we && !clr_val |=> !err_flag && err_lanes == '0);
endmodule

// File: tb/byte_parity_guard_tb_top.sv
`timescale 1ns/1ps
module byte_parity_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, inj_en = 1'b0;
  logic [1:0] det_type = 2'b01;
  logic wr_valid = 1'b0, wr_src = 1'b0;
  logic [7:0] wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [7:0] wr_par, wr_par_we;
  logic rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0] rd_par = '0;
  logic clr_we = 1'b0, clr_val = 1'b0;
  logic err_flag;
  logic [7:0] err_lanes;
  int checks = 0, errors = 0;
  logic [7:0] saved;

  always #2.5 clk = ~clk;

  byte_parity_guard #(.DATA_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .inj_en(inj_en), .det_type(det_type),
    .wr_valid(wr_valid), .wr_src(wr_src), .wr_be(wr_be), .wr_data(wr_data),
    .wr_par(wr_par), .wr_par_we(wr_par_we), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_par(rd_par), .clr_we(clr_we), .clr_val(clr_val), .err_flag(err_flag),
    .err_lanes(err_lanes));

  // {data, inj, src, expected parity}
  localparam logic [73:0] VEC [10] = '{
    {64'h0000_0000_0000_0000, 1'b0, 1'b0, 8'h00},
    {64'h0000_0000_0000_0000, 1'b1, 1'b0, 8'hFF},
    {64'h0000_0000_0000_0000, 1'b1, 1'b1, 8'hFF},
    {64'h0102_0408_1020_4080, 1'b0, 1'b1, 8'hFF},
    {64'h0102_0408_1020_4080, 1'b1, 1'b0, 8'h00},
    {64'h0300_0000_0000_00FF, 1'b0, 1'b0, 8'h00},
    {64'h0300_0000_0000_00FF, 1'b1, 1'b1, 8'hFF},
    {64'h0000_0000_0000_0007, 1'b0, 1'b0, 8'h01},
    {64'h0000_0000_0000_0007, 1'b1, 1'b1, 8'hFE},
    {64'h8000_0000_0000_0001, 1'b1, 1'b1, 8'h7E}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 flag", {63'd0, err_flag}, 64'd0);
    check("R10 lanes", {56'd0, err_lanes}, 64'd0);
    rst_n = 1'b1;
    cyc();

    for (int i = 0; i < 10; i++) begin
      wr_valid = 1'b1; wr_be = 8'hFF;
      {wr_data, inj_en, wr_src} = VEC[i][73:8];
      #1;
      check("R1 R3 R4 parity", {56'd0, wr_par}, {56'd0, VEC[i][7:0]});
      check("R2 strobe", {56'd0, wr_par_we}, 64'h FF);
      @(negedge clk);
    end
    chk_en = 1'b1; inj_en = 1'b1; wr_src = 1'b0; wr_data = 64'h0000_0000_0000_0007;
    #1 check("R3 inj with chk_en", {56'd0, wr_par}, 64'hFE);
    inj_en = 1'b0; chk_en = 1'b0;
    wr_be = 8'h5A; #1 check("R2 partial be", {56'd0, wr_par_we}, 64'h5A);
    wr_valid = 1'b0; #1 check("R2 no valid", {56'd0, wr_par_we}, 64'h00);
    @(negedge clk);

    rd_valid = 1'b1; rd_data = '0; rd_par = 8'h03; cyc();
    rd_valid = 1'b0;
    check("R6 masked", {55'd0, err_flag, err_lanes}, 64'd0);

    chk_en = 1'b1; rd_valid = 1'b1; #1;
    check("R5 not early", {63'd0, err_flag}, 64'd0);
    cyc(); rd_valid = 1'b0;
    check("R5 flag", {63'd0, err_flag}, 64'd1);
    check("R5 lanes", {56'd0, err_lanes}, 64'h03);

    rd_valid = 1'b1; rd_par = 8'hC0; cyc(); rd_valid = 1'b0;
    check("R8 sticky lanes", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'h03});
    chk_en = 1'b0; rd_valid = 1'b1; rd_par = 8'h10; cyc(); rd_valid = 1'b0;
    check("R6 masked while set", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'h03});
    chk_en = 1'b1;

    clr_we = 1'b1; clr_val = 1'b1; cyc();
    check("R9 write one", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'h03});
    clr_val = 1'b0; cyc(); clr_we = 1'b0;
    check("R9 clear", {55'd0, err_flag, err_lanes}, 64'd0);

    det_type = 2'b00; rd_valid = 1'b1; rd_par = 8'h10; cyc(); rd_valid = 1'b0;
    check("R7 type 00", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'h10});
    clr_we = 1'b1; clr_val = 1'b0; cyc(); clr_we = 1'b0;
    det_type = 2'b10; rd_valid = 1'b1; cyc(); rd_valid = 1'b0;
    check("R7 type 1x", {55'd0, err_flag, err_lanes}, 64'd0);
    det_type = 2'b11; rd_valid = 1'b1; cyc(); rd_valid = 1'b0;
    check("R7 type 11", {55'd0, err_flag, err_lanes}, 64'd0);
    det_type = 2'b01;

    rd_valid = 1'b1; rd_par = 8'h01; cyc();
    rd_par = 8'h80; clr_we = 1'b1; clr_val = 1'b0; cyc();
    rd_valid = 1'b0; clr_we = 1'b0;
    check("R9 set wins", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'h80});
    clr_we = 1'b1; cyc(); clr_we = 1'b0;

    wr_valid = 1'b1; wr_be = 8'hFF; wr_data = 64'h1234_5678_9ABC_DEF0; inj_en = 1'b1; #1;
    saved = wr_par; inj_en = 1'b0; wr_valid = 1'b0;
    rd_valid = 1'b1; rd_data = 64'h1234_5678_9ABC_DEF0; rd_par = saved; cyc(); rd_valid = 1'b0;
    check("R3 injected readback", {55'd0, err_flag, err_lanes}, {55'd0, 1'b1, 8'hFF});
    clr_we = 1'b1; cyc(); clr_we = 1'b0;
    wr_valid = 1'b1; #1; saved = wr_par; wr_valid = 1'b0;
    rd_valid = 1'b1; rd_par = saved; cyc(); rd_valid = 1'b0;
    check("R1 clean readback", {55'd0, err_flag, err_lanes}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule